// File: doc/BRIEF.md
# Status and Register Width Controller

This block keeps the processor status byte, the separate emulation bit, the accumulator and the two index registers of a 16-bit capable core. It applies the run-time width rules: the accumulator and the index registers can each be 8 or 16 bits wide, chosen by two bits of the status byte. An 8-bit accumulator keeps its upper byte out of the way and intact. An 8-bit index setting wipes the upper bytes of both index registers.

An instruction decoder drives the operation strobe with a 2-bit selector and an 8-bit mask. The selector picks one of four operations: OR the mask into the status, clear the masked status bits, exchange carry with the emulation bit, or swap the accumulator bytes. In the same cycle, the register file side accepts 16-bit write data for any of the three registers, and the ALU can return its four result flags. Every state element is registered, so each change shows on the outputs one clock edge after the cycle that requested it.

Top module: `status_width_ctrl`

## Requirements
- R1: After reset the status byte is 0x34 (IRQ-disable bit 2, index-width bit 4 and accumulator-width bit 5 set, all other bits 0), the emulation bit is 1, and the accumulator, X and Y are 0.
- R2: Selector 0 (set-bits) makes the next status byte the current status byte ORed with the mask. Bit positions: carry 0, zero 1, IRQ-disable 2, decimal 3, index width 4, accumulator width 5, overflow 6, negative 7.
- R3: Selector 1 (reset-bits) clears every status bit whose mask bit is 1 and leaves the other bits as they were.
- R4: Selector 2 (exchange) moves the old carry into the emulation bit and the old emulation bit into carry, both at the same clock edge.
- R5: While the emulation bit is 1, both width bits read 1 and reset-bits cannot clear them. Leaving emulation through an exchange leaves both width bits at 1.
- R6: A write to the accumulator stores all 16 bits when bit 5 is 0. When bit 5 is 1, the write stores only the low byte and the high byte keeps its value.
- R7: A write to X or Y stores all 16 bits when bit 4 is 0. When bit 4 is 1, the write stores the low byte and the high byte becomes 0.
- R8: When the next index-width bit is 1, including a change made by set-bits or by entering emulation, the high bytes of X and Y read 0 from the next cycle on. They stay 0 after the width returns to 16 bits.
- R9: The accumulator high byte keeps its value when the accumulator width goes to 8 bits and back to 16 bits.
- R10: Selector 3 (swap) exchanges the accumulator bytes at either width. If an accumulator write arrives in the same cycle, the write takes effect and the swap does not.
- R11: The ALU flag update loads aluFlags bits 3,2,1,0 into status bits 7,6,1,0. The update is ignored in a cycle where the strobe is active with selector 0, 1 or 2, and it applies when the strobe carries selector 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation strobe |
| opSel | input | 2 | Operation: 0 set-bits, 1 reset-bits, 2 exchange, 3 swap |
| opMask | input | 8 | Immediate mask for set-bits and reset-bits |
| wrData | input | 16 | Register write data |
| wrAcc | input | 1 | Accumulator write enable |
| wrIdxX | input | 1 | X write enable |
| wrIdxY | input | 1 | Y write enable |
| aluWe | input | 1 | ALU flag update enable |
| aluFlags | input | 4 | ALU flags {negative, overflow, zero, carry} |
| pByte | output | 8 | Status byte |
| emuMode | output | 1 | Emulation bit |
| accOut | output | 16 | Accumulator |
| xOut | output | 16 | X index |
| yOut | output | 16 | Y index |
| accNarrow | output | 1 | Accumulator is 8 bits wide |
| idxNarrow | output | 1 | Index registers are 8 bits wide |

## Verification
A width bit that is stored wrongly shows at once on pByte and the narrow outputs. It also shows on the next register write, which comes back with the wrong number of bytes. A missed clear of an index high byte stays hidden while the width is 8 bits, so the bench widens the registers again and reads xOut and yOut. A lost accumulator high byte only appears after a return to 16 bits or after a swap. Every scenario therefore ends by reading the register back in the other width, one edge after the request.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_SET  = 2'd0,
    OP_CLR  = 2'd1,
    OP_XCHG = 2'd2,
    OP_SWAP = 2'd3
  } opcode_e;

  localparam int P_C = 0;
  localparam int P_Z = 1;
  localparam int P_I = 2;
  localparam int P_D = 3;
  localparam int P_X = 4;
  localparam int P_M = 5;
  localparam int P_V = 6;
  localparam int P_N = 7;
  localparam logic [7:0] P_RESET = 8'h34;

  typedef struct packed {
    logic accNarrow;
    logic idxNarrow;
    logic clearIdxHi;
    logic swapAcc;
    logic wrAcc;
    logic wrX;
    logic wrY;
  } ctrl_t;
endpackage

// File: rtl/swc_control.sv
module swc_control
  import swc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opSel,
  input  logic [7:0] opMask,
  input  logic       wrAcc,
  input  logic       wrIdxX,
  input  logic       wrIdxY,
  input  logic       aluWe,
  input  logic [3:0] aluFlags,
  output logic [7:0] pByte,
  output logic       emuMode,
  output ctrl_t      ctrl
);
  logic [7:0] pReg, pNext;
  logic       emuReg, emuNext;
  opcode_e    op;
  logic       opTouchesP;

  assign op         = opcode_e'(opSel);
  assign opTouchesP = opValid && (op != OP_SWAP);

  always_comb begin
    pNext   = pReg;
    emuNext = emuReg;
    if (aluWe && !opTouchesP) begin
      pNext[P_N] = aluFlags[3];
      pNext[P_V] = aluFlags[2];
      pNext[P_Z] = aluFlags[1];
      pNext[P_C] = aluFlags[0];
    end
    if (opValid) begin
      unique case (op)
        OP_SET:  pNext = pReg | opMask;
        OP_CLR:  pNext = pReg & ~opMask;
        OP_XCHG: begin
          emuNext    = pReg[P_C];
          pNext[P_C] = emuReg;
        end
        default: ;
      endcase
    end
    // Emulation (current or entering) and leaving it both pin the widths.
    if (emuNext || emuReg) begin
      pNext[P_M] = 1'b1;
      pNext[P_X] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pReg   <= P_RESET;
      emuReg <= 1'b1;
    end else begin
      pReg   <= pNext;
      emuReg <= emuNext;
    end
  end

  assign pByte   = pReg;
  assign emuMode = emuReg;

  always_comb begin
    ctrl.accNarrow  = pReg[P_M];
    ctrl.idxNarrow  = pReg[P_X];
    ctrl.clearIdxHi = pNext[P_X];
    ctrl.swapAcc    = opValid && (op == OP_SWAP);
    ctrl.wrAcc      = wrAcc;
    ctrl.wrX        = wrIdxX;
    ctrl.wrY        = wrIdxY;
  end

  p_emu_widths_r5: assert property (@(posedge clk) disable iff (!rstN)
    emuReg |-> (pReg[P_M] && pReg[P_X]));

  p_xchg_swap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op == OP_XCHG) |=> (emuReg == $past(pReg[P_C])) && (pReg[P_C] == $past(emuReg)));

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op == OP_SET) |=> ((pReg & $past(opMask)) == $past(opMask)));

  p_alu_blocked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op == OP_CLR && aluWe) |=> (pReg[P_C] == ($past(pReg[P_C]) & ~$past(opMask[P_C]))));
endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctrl,
  input  logic [2*BW-1:0] wrData,
  output logic [2*BW-1:0] accOut,
  output logic [2*BW-1:0] xOut,
  output logic [2*BW-1:0] yOut
);
  localparam int WW = 2 * BW;
  localparam int NIDX = 2;

  logic [WW-1:0] accReg, accNext;

  always_comb begin
    accNext = accReg;
    if (ctrl.wrAcc)
      accNext = ctrl.accNarrow ? {accReg[WW-1:BW], wrData[BW-1:0]} : wrData;
    else if (ctrl.swapAcc)
      accNext = {accReg[BW-1:0], accReg[WW-1:BW]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accReg <= '0;
    else       accReg <= accNext;
  end

  assign accOut = accReg;

  logic [NIDX-1:0] idxWe;
  logic [WW-1:0]   idxVal [NIDX];
  assign idxWe = {ctrl.wrY, ctrl.wrX};

  for (genvar g = 0; g < NIDX; g++) begin : gIdx
    logic [WW-1:0] regQ, regD;
    always_comb begin
      regD = regQ;
      if (idxWe[g])
        regD = ctrl.idxNarrow ? {{BW{1'b0}}, wrData[BW-1:0]} : wrData;
      if (ctrl.clearIdxHi)
        regD[WW-1:BW] = '0;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ <= '0;
      else       regQ <= regD;
    end
    assign idxVal[g] = regQ;

    p_idx_hi_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.clearIdxHi |=> (regQ[WW-1:BW] == '0));
  end

  assign xOut = idxVal[0];
  assign yOut = idxVal[1];

  p_acc_hi_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrAcc && ctrl.accNarrow) |=> (accReg[WW-1:BW] == $past(accReg[WW-1:BW])));

  p_swap_bytes_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.swapAcc && !ctrl.wrAcc) |=> (accReg == {$past(accReg[BW-1:0]), $past(accReg[WW-1:BW])}));
endmodule

// File: rtl/status_width_ctrl.sv
module status_width_ctrl
  import swc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [1:0]  opSel,
  input  logic [7:0]  opMask,
  input  logic [15:0] wrData,
  input  logic        wrAcc,
  input  logic        wrIdxX,
  input  logic        wrIdxY,
  input  logic        aluWe,
  input  logic [3:0]  aluFlags,
  output logic [7:0]  pByte,
  output logic        emuMode,
  output logic [15:0] accOut,
  output logic [15:0] xOut,
  output logic [15:0] yOut,
  output logic        accNarrow,
  output logic        idxNarrow
);
  ctrl_t ctrl;

  swc_control uControl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .opMask(opMask),
    .wrAcc(wrAcc), .wrIdxX(wrIdxX), .wrIdxY(wrIdxY), .aluWe(aluWe),
    .aluFlags(aluFlags), .pByte(pByte), .emuMode(emuMode), .ctrl(ctrl)
  );

  swc_datapath #(.BW(BYTE_W)) uDatapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData),
    .accOut(accOut), .xOut(xOut), .yOut(yOut)
  );

  assign accNarrow = pByte[P_M];
  assign idxNarrow = pByte[P_X];
endmodule

// File: tb/status_width_ctrl_test.sv
module status_width_ctrl_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        opValid = 0;
  logic [1:0]  opSel = 0;
  logic [7:0]  opMask = 0;
  logic [15:0] wrData = 0;
  logic        wrAcc = 0, wrIdxX = 0, wrIdxY = 0, aluWe = 0;
  logic [3:0]  aluFlags = 0;
  logic [7:0]  pByte;
  logic        emuMode;
  logic [15:0] accOut, xOut, yOut;
  logic        accNarrow, idxNarrow;
  int total = 0;
  int bad = 0;

  status_width_ctrl uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    opValid = 0; wrAcc = 0; wrIdxX = 0; wrIdxY = 0; aluWe = 0;
  endtask

  // Inputs are set at a falling edge; one rising edge later the result is read at the next falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic doOp(input logic [1:0] s, input logic [7:0] m);
    opValid = 1; opSel = s; opMask = m; tick();
  endtask

  task automatic wr(input logic a, input logic x, input logic y, input logic [15:0] d);
    wrAcc = a; wrIdxX = x; wrIdxY = y; wrData = d; tick();
  endtask

  task automatic testReset();
    chk("R1 p", pByte, 16'h34); chk("R1 e", emuMode, 1);
    chk("R1 a", accOut, 0); chk("R1 x", xOut, 0); chk("R1 y", yOut, 0);
    chk("R1 widths", {accNarrow, idxNarrow}, 2'b11);
  endtask

  task automatic testEmuLock();
    doOp(2'd1, 8'h34);
    chk("R5 clear in emulation", pByte, 16'h30);
  endtask

  task automatic testSetBits();
    doOp(2'd0, 8'h09);
    chk("R2 set", pByte, 16'h39);
  endtask

  task automatic testExchange();
    doOp(2'd1, 8'h01);
    chk("R3 clear carry", pByte, 16'h38);
    doOp(2'd2, 8'h00);
    chk("R4 e from carry", emuMode, 0);
    chk("R4 carry from e / R5 widths", pByte, 16'h39);
  endtask

  task automatic testResetBits();
    doOp(2'd1, 8'h38);
    chk("R3 clear", pByte, 16'h01);
    chk("R3 widths", {accNarrow, idxNarrow}, 2'b00);
  endtask

  task automatic testWideWrites();
    wr(1, 0, 0, 16'hBEEF);
    wr(0, 1, 0, 16'h1234);
    wr(0, 0, 1, 16'h5678);
    chk("R6 wide acc", accOut, 16'hBEEF);
    chk("R7 wide x", xOut, 16'h1234);
    chk("R7 wide y", yOut, 16'h5678);
  endtask

  task automatic testAccNarrow();
    doOp(2'd0, 8'h20);
    wr(1, 0, 0, 16'h00AA);
    chk("R6 narrow acc", accOut, 16'hBEAA);
    doOp(2'd1, 8'h20);
    chk("R9 acc hi kept", accOut, 16'hBEAA);
    chk("R9 p", pByte, 16'h01);
  endtask

  task automatic testIdxNarrow();
    doOp(2'd0, 8'h10);
    chk("R8 x cleared", xOut, 16'h0034);
    chk("R8 y cleared", yOut, 16'h0078);
    wr(0, 1, 0, 16'hFFFF);
    chk("R7 narrow x", xOut, 16'h00FF);
    doOp(2'd1, 8'h10);
    chk("R8 x after widen", xOut, 16'h00FF);
    chk("R8 y after widen", yOut, 16'h0078);
  endtask

  task automatic testSwap();
    doOp(2'd3, 8'h00);
    chk("R10 swap wide", accOut, 16'hAABE);
    doOp(2'd0, 8'h20);
    doOp(2'd3, 8'h00);
    chk("R10 swap narrow", accOut, 16'hBEAA);
    opValid = 1; opSel = 2'd3; wrAcc = 1; wrData = 16'h1122; tick();
    chk("R10 write beats swap", accOut, 16'hBE22);
  endtask

  task automatic testAlu();
    aluWe = 1; aluFlags = 4'hF; tick();
    chk("R11 alu load", pByte, 16'hE3);
    aluWe = 1; aluFlags = 4'h0; opValid = 1; opSel = 2'd0; opMask = 8'h00; tick();
    chk("R11 alu ignored", pByte, 16'hE3);
    aluWe = 1; aluFlags = 4'h0; opValid = 1; opSel = 2'd3; tick();
    chk("R11 alu with swap", pByte, 16'h20);
    chk("R10 swap with alu", accOut, 16'h22BE);
  endtask

  task automatic testEnterEmu();
    doOp(2'd0, 8'h01);
    doOp(2'd1, 8'h30);
    wr(0, 1, 0, 16'hABCD);
    chk("R7 wide x again", xOut, 16'hABCD);
    doOp(2'd2, 8'h00);
    chk("R4 back to emulation", emuMode, 1);
    chk("R5 widths forced", pByte, 16'h30);
    chk("R8 x cleared on emulation", xOut, 16'h00CD);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testEmuLock();
    testSetBits();
    testExchange();
    testResetBits();
    testWideWrites();
    testAccNarrow();
    testIdxNarrow();
    testSwap();
    testAlu();
    testEnterEmu();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule